// File: doc/BRIEF.md
# Octal DAC Serial Command Front End

This block is the digital side of an eight-channel, 8-bit voltage DAC. A host sends 16-bit command words over an SPI-style link: chip select, a serial clock that idles low, and data sampled on the rising clock edge. When chip select returns high, the block decodes the word and acts on it. A word can load a channel's input register, load that register and its DAC register together, copy every input register into its DAC register, or set when the serial output changes.

The serial output is the far end of the internal shift path, so several devices can be chained. It can change on the falling clock edge, with a lag of 16.5 clocks, or on the rising edge, with a lag of 16 clocks. It always drives a level. A level-sensitive load input, when held low, makes the DAC registers transparent, so any input register write shows on its channel output at once.

The serial pins are sampled by the block's own system clock through synchronizers. The serial clock must therefore run well below the system clock. The eight DAC codes are presented as one flat bus.

Top module: `sdac_ctrl`

## Requirements
- R1: A frame is shifted in MSB first. Of the 16 bits taken at the last chip-select rise, bits 15:14 are ignored, bits 13:11 are the channel address, bits 10:8 are the opcode and bits 7:0 are the data. Channel n occupies bits n*8+7:n*8 of `dac_o`.
- R2: Opcode 001 writes the data into the addressed input register only. With `ldac_ni` high, `dac_o` does not change.
- R3: Opcode 010 writes the data into the addressed input register and DAC register. The other channels do not change.
- R4: Opcode 011 copies all eight input registers into their DAC registers. Address and data are ignored.
- R5: Opcode 000 and the reserved opcodes 110 and 111 change no register and do not change the output mode.
- R6: A frame is acted on only if a positive multiple of 16 rising clock edges occurred while chip select was low, and then only its last 16 bits are decoded. Any other count discards the frame with no register change.
- R7: While `ldac_ni` is low, each channel of `dac_o` follows its input register with no clock edge in between. On the rise of `ldac_ni`, the DAC registers hold those values.
- R8: In mode 0, `dout_o` changes only after falling serial clock edges. During the high phase of rising edge k it shows the bit taken at rising edge k-17. Opcode 100 selects mode 0.
- R9: In mode 1, `dout_o` changes only after rising serial clock edges. During the high phase of rising edge k it shows the bit taken at edge k-16. Opcode 101 selects mode 1, and the new mode takes effect from the next frame.
- R10: After reset, every input and DAC register is zero, `dout_o` is low and the output mode is mode 0.
- R11: While chip select is high, `dout_o` holds its value and serial clock edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; its rise commits the frame |
| sclk_i | input | 1 | Serial clock, idles low |
| din_i | input | 1 | Serial data in, taken on the rising serial clock edge |
| ldac_ni | input | 1 | Level-sensitive load; low makes the DAC registers transparent |
| dout_o | output | 1 | Serial data out for daisy-chaining |
| dac_o | output | 64 | Eight 8-bit DAC codes, channel 0 in the low byte |

## Verification
The bench uses the default parameters: eight channels, 8-bit data, two ignored lead bits and two synchronizer stages. These give a 16-bit frame and a 17-stage output path. The defaults make every opcode value reachable, including both reserved codes. They also make the 16 and 16.5 clock lags exact bit positions that can be checked in a 32-bit chained transfer. Frames of 15 and 17 bits sit on either side of the 16-bit boundary, so discard and acceptance are both exercised with the widths the block ships with.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int CTRL_W = 3;

  typedef enum logic [CTRL_W-1:0] {
    OP_NOP       = 3'b000,
    OP_LOAD      = 3'b001,
    OP_LOAD_UPD  = 3'b010,
    OP_UPD_ALL   = 3'b011,
    OP_DOUT_FALL = 3'b100,
    OP_DOUT_RISE = 3'b101
  } op_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int FRAME_W = 16,
  parameter int PAY_W   = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             sclk_i,
  input  logic             din_i,
  input  logic             mode_rise_i,
  output logic [PAY_W-1:0] payload_o,
  output logic             commit_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             dout_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  // one stage beyond the frame gives the extra half-cycle of lag in mode 0
  logic [FRAME_W:0]   sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               full_q, sclk_q, cs_q, dout_q;

  assign rise_o = !cs_n_i &&  sclk_i && !sclk_q;
  assign fall_o = !cs_n_i && !sclk_i &&  sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_n_i;
      if (cs_n_i) begin
        cnt_q  <= '0;
        full_q <= 1'b0;
      end else if (rise_o) begin
        sr_q <= {sr_q[FRAME_W-1:0], din_i};
        if (cnt_q == CNT_LAST) begin
          cnt_q  <= '0;
          full_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     dout_q <= 1'b0;
    else if (rise_o &&  mode_rise_i) dout_q <= sr_q[FRAME_W-1];
    else if (fall_o && !mode_rise_i) dout_q <= sr_q[FRAME_W];
  end

  assign dout_o    = dout_q;
  assign payload_o = sr_q[PAY_W-1:0];
  assign commit_o  = cs_n_i && !cs_q && full_q && (cnt_q == '0);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     commit_i,
  input  op_e                      op_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     ldac_ni,
  output logic [NUM_CH*DATA_W-1:0] in_o,
  output logic [NUM_CH*DATA_W-1:0] dac_o
);
  logic wr_in, wr_one, wr_all;

  assign wr_in  = commit_i && (op_i == OP_LOAD || op_i == OP_LOAD_UPD);
  assign wr_one = commit_i && (op_i == OP_LOAD_UPD);
  assign wr_all = commit_i && (op_i == OP_UPD_ALL);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [DATA_W-1:0] in_q, dac_q;
    logic              hit;

    assign hit = (addr_i == ADDR_W'(ch));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q  <= '0;
        dac_q <= '0;
      end else begin
        if (wr_in && hit) in_q <= data_i;
        // transparent phase: keep the register tracking so it holds on release
        if (!ldac_ni)              dac_q <= in_q;
        else if (wr_one && hit)    dac_q <= data_i;
        else if (wr_all)           dac_q <= in_q;
      end
    end

    assign in_o [ch*DATA_W +: DATA_W] = in_q;
    assign dac_o[ch*DATA_W +: DATA_W] = dac_q;
  end
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DATA_W      = 8,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_ni,
  input  logic                     sclk_i,
  input  logic                     din_i,
  input  logic                     ldac_ni,
  output logic                     dout_o,
  output logic [NUM_CH*DATA_W-1:0] dac_o
);
  localparam int ADDR_W  = $clog2(NUM_CH);
  localparam int PAY_W   = ADDR_W + CTRL_W + DATA_W;
  localparam int FRAME_W = PAD_W + PAY_W;

  logic                     cs_s, sclk_s, din_s;
  logic [PAY_W-1:0]         payload;
  logic                     commit, sclk_rise, sclk_fall, mode_q;
  op_e                      op;
  logic [ADDR_W-1:0]        addr;
  logic [DATA_W-1:0]        data;
  logic [NUM_CH*DATA_W-1:0] in_w, dac_w;

  sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, din_i}),
    .q_o   ({cs_s, sclk_s, din_s})
  );

  sdac_shift #(.FRAME_W(FRAME_W), .PAY_W(PAY_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_s),
    .sclk_i     (sclk_s),
    .din_i      (din_s),
    .mode_rise_i(mode_q),
    .payload_o  (payload),
    .commit_o   (commit),
    .rise_o     (sclk_rise),
    .fall_o     (sclk_fall),
    .dout_o     (dout_o)
  );

  assign data = payload[DATA_W-1:0];
  assign op   = op_e'(payload[DATA_W +: CTRL_W]);
  assign addr = payload[DATA_W+CTRL_W +: ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           mode_q <= 1'b0;
    else if (commit && op == OP_DOUT_RISE) mode_q <= 1'b1;
    else if (commit && op == OP_DOUT_FALL) mode_q <= 1'b0;
  end

  sdac_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .op_i    (op),
    .addr_i  (addr),
    .data_i  (data),
    .ldac_ni (ldac_ni),
    .in_o    (in_w),
    .dac_o   (dac_w)
  );

  // asynchronous path: the load pin selects the output with no clock
  assign dac_o = ldac_ni ? dac_w : in_w;
endmodule

// File: rtl/sdac_ctrl_chk.sv
module sdac_ctrl_chk #(
  parameter int DAC_BITS = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_s_i,
  input logic                ldac_ni,
  input logic                commit_i,
  input logic                mode_i,
  input logic                rise_i,
  input logic                fall_i,
  input logic                dout_i,
  input logic [DAC_BITS-1:0] in_i,
  input logic [DAC_BITS-1:0] dac_i
);
  // R11
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> $stable(dout_i));

  // R6
  in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(in_i));

  // R7
  dac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldac_ni && !commit_i) |=> (!ldac_ni || $stable(dac_i)));

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(mode_i));

  // R8
  fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !fall_i) |=> $stable(dout_i));

  // R9
  rise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !rise_i) |=> $stable(dout_i));
endmodule

bind sdac_ctrl sdac_ctrl_chk #(.DAC_BITS(NUM_CH*DATA_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_s_i  (cs_s),
  .ldac_ni (ldac_ni),
  .commit_i(commit),
  .mode_i  (mode_q),
  .rise_i  (sclk_rise),
  .fall_i  (sclk_fall),
  .dout_i  (dout_o),
  .in_i    (in_w),
  .dac_i   (dac_o)
);

// File: tb/sdac_ctrl_tb_top.sv
module sdac_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, sclk_i = 1'b0, din_i = 1'b0, ldac_ni = 1'b1;
  logic        dout_o;
  logic [63:0] dac_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_in [8];
  logic [7:0] exp_dac [8];
  bit exp_mode = 0;

  always #5 clk_i = ~clk_i;

  sdac_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i),
    .din_i(din_i), .ldac_ni(ldac_ni), .dout_o(dout_o), .dac_o(dac_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [15:0] cmd(input logic [2:0] op, input logic [2:0] a,
                                      input logic [7:0] d);
    return {2'b00, a, op, d};
  endfunction

  // reference model of a committed 16-bit word (R1..R5)
  function automatic void model(input logic [15:0] w);
    logic [2:0] a;
    logic [2:0] op;
    a  = w[13:11];
    op = w[10:8];
    case (op)
      3'b001: exp_in[a] = w[7:0];
      3'b010: begin exp_in[a] = w[7:0]; exp_dac[a] = w[7:0]; end
      3'b011: for (int i = 0; i < 8; i++) exp_dac[i] = exp_in[i];
      3'b100: exp_mode = 0;
      3'b101: exp_mode = 1;
      default: ;
    endcase
    if (!ldac_ni) for (int i = 0; i < 8; i++) exp_dac[i] = exp_in[i];
  endfunction

  function automatic logic [63:0] exp_vec();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = ldac_ni ? exp_dac[i] : exp_in[i];
    return v;
  endfunction

  // sends the low n bits of w, MSB first; dchk 1/2 checks the mode 0/1 lag
  task automatic send(input logic [31:0] w, input int n, input int dchk);
    int bad = 0;
    logic act_b = 1'b0, exp_b = 1'b0;
    cs_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    for (int k = 1; k <= n; k++) begin
      din_i = w[n-k];
      repeat (8) @(negedge clk_i);
      sclk_i = 1'b1;
      repeat (7) @(negedge clk_i);
      if ((dchk == 1 && k >= 18) || (dchk == 2 && k >= 17)) begin
        logic e;
        e = (dchk == 1) ? w[n-k+17] : w[n-k+16];
        if (dout_o !== e && bad == 0) begin act_b = dout_o; exp_b = e; end
        if (dout_o !== e) bad++;
      end
      @(negedge clk_i);
      sclk_i = 1'b0;
    end
    repeat (8) @(negedge clk_i);
    cs_ni = 1'b1;
    repeat (12) @(negedge clk_i);
    if (n > 0 && n % 16 == 0) model(w[15:0]);
    if (dchk == 1) check(bad == 0, "R8", "mode 0 lag of 16.5", act_b, exp_b);
    if (dchk == 2) check(bad == 0, "R9", "mode 1 lag of 16", act_b, exp_b);
  endtask

  task automatic t_reset();
    check(dout_o === 1'b0, "R10", "dout after reset", dout_o, 0);
    check(dac_o === 64'h0, "R10", "dac after reset", dac_o, 0);
  endtask

  task automatic t_load();
    send(cmd(3'b001, 3'd3, 8'hA5), 16, 0);
    check(dac_o === exp_vec(), "R2", "load input only", dac_o, exp_vec());
  endtask

  task automatic t_load_upd();
    send({2'b11, 3'd5, 3'b010, 8'h3C}, 16, 0);
    check(dac_o === exp_vec() && dac_o[47:40] === 8'h3C, "R3",
          "load and update ch5", dac_o, exp_vec());
    send(cmd(3'b010, 3'd7, 8'hE1), 16, 0);
    check(dac_o[63:56] === 8'hE1 && dac_o === exp_vec(), "R1",
          "top address ch7", dac_o, exp_vec());
  endtask

  task automatic t_upd_all();
    send(cmd(3'b001, 3'd0, 8'h77), 16, 0);
    send(cmd(3'b001, 3'd7, 8'h08), 16, 0);
    check(dac_o === exp_vec(), "R2", "two loads no dac change", dac_o, exp_vec());
    send(cmd(3'b011, 3'd2, 8'hFF), 16, 0);
    check(dac_o === exp_vec() && dac_o[31:24] === 8'hA5 && dac_o[7:0] === 8'h77,
          "R4", "update all", dac_o, exp_vec());
  endtask

  task automatic t_nop();
    send(cmd(3'b000, 3'd1, 8'h12), 16, 0);
    send(cmd(3'b110, 3'd1, 8'h34), 16, 0);
    send(cmd(3'b111, 3'd1, 8'h56), 16, 0);
    send(cmd(3'b011, 3'd0, 8'h00), 16, 0);
    check(dac_o === exp_vec() && dac_o[15:8] === 8'h00, "R5",
          "nop and reserved codes", dac_o, exp_vec());
  endtask

  task automatic t_short();
    send({17'h0, cmd(3'b010, 3'd1, 8'h99)} >> 1, 15, 0);
    check(dac_o === exp_vec(), "R6", "15-bit frame discarded", dac_o, exp_vec());
    send({15'h0, 1'b1, cmd(3'b010, 3'd1, 8'h99)}, 17, 0);
    check(dac_o === exp_vec() && dac_o[15:8] === 8'h00, "R6",
          "17-bit frame discarded", dac_o, exp_vec());
  endtask

  task automatic t_chain();
    send({cmd(3'b010, 3'd1, 8'h5A), cmd(3'b010, 3'd2, 8'hC6)}, 32, 0);
    check(dac_o === exp_vec() && dac_o[23:16] === 8'hC6 && dac_o[15:8] === 8'h00,
          "R6", "32-bit frame decodes last word", dac_o, exp_vec());
  endtask

  task automatic t_ldac();
    ldac_ni = 1'b0;
    for (int i = 0; i < 8; i++) exp_dac[i] = exp_in[i];
    #1;
    check(dac_o === exp_vec(), "R7", "transparent on ldac low", dac_o, exp_vec());
    @(negedge clk_i);
    send(cmd(3'b001, 3'd4, 8'h99), 16, 0);
    check(dac_o[39:32] === 8'h99, "R7", "input write seen while transparent",
          dac_o, exp_vec());
    ldac_ni = 1'b1;
    #1;
    check(dac_o === exp_vec(), "R7", "dac holds on ldac release", dac_o, exp_vec());
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_dout();
    send({16'hF85A, 16'h0000}, 32, 1);
    send(cmd(3'b101, 3'd0, 8'h00), 16, 0);
    send({16'h38C3, 16'h0000}, 32, 2);
    send(cmd(3'b100, 3'd0, 8'h00), 16, 0);
    send({16'hC5E7, 16'h0000}, 32, 1);
    check(dac_o === exp_vec(), "R5", "mode commands leave registers",
          dac_o, exp_vec());
  endtask

  task automatic t_hold();
    logic d0;
    d0 = dout_o;
    din_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      repeat (8) @(negedge clk_i);
      sclk_i = 1'b1;
      repeat (8) @(negedge clk_i);
      sclk_i = 1'b0;
    end
    repeat (10) @(negedge clk_i);
    check(dout_o === d0, "R11", "dout held with cs high", dout_o, d0);
    check(dac_o === exp_vec(), "R11", "edges ignored with cs high",
          dac_o, exp_vec());
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin exp_in[i] = '0; exp_dac[i] = '0; end
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    t_reset();
    t_load();
    t_load_upd();
    t_upd_all();
    t_nop();
    t_short();
    t_chain();
    t_ldac();
    t_dout();
    t_hold();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule